// File: doc/BRIEF.md
# Late-write pipelined SRAM

This block is a synchronous single-port word memory. It takes an address and its control on one rising clock edge. The write data for a write then follows on the next rising edge. Each word is split into 9-bit byte lanes, and each lane has its own active-low write enable. A write that enables no lane is an abort and leaves memory unchanged. Read data passes through an output register, so it is presented one cycle after the edge that sampled the read address.

A write whose data has just arrived is held in a one-entry pending buffer. The buffer moves the write into the array on the following edge. A read of the same address in the meantime is merged lane by lane with that buffer, so reads and writes always look coherent to the user.

The output bus has a tri-state enable that follows a two-cycle deselect rule. A write turns the bus off when its data cycle starts. A sleep input makes a sampling edge act as a deselect. Stored contents are kept during sleep.

Top module: `lw_sram`

## Requirements
- R1: While reset is low and after it, before any read is sampled, `rd_valid`, `drive_en` and `rdata` are all zero and no write is pending.
- R2: On each rising edge with `sleep` low, the block decodes its control inputs as follows:
  - `sel_n`=0 and `wr_n`=0 is a write.
  - `sel_n`=0 and `wr_n`=1 is a read.
  - `sel_n`=1 is a deselect.
  - The `addr` and `be_n` values sampled on that edge belong to the operation.
- R3: The write data for a write sampled at edge E is taken from `wdata` at edge E+1. The value on `wdata` at edge E is ignored.
- R4: Lane i is `wdata[9*i+8:9*i]`, and `be_n[i]`=0 writes it. Lanes whose enable is high keep their old contents. `WORD_W` is 18 (two lanes) or 36 (four lanes).
- R5: A write with every `be_n` bit high (abort) leaves the addressed word unchanged.
- R6: A read sampled at edge E loads `rdata` at edge E+1, and `rd_valid` is high for exactly that one cycle. At all other times `rdata` holds its last value.
- R7: A read sampled on the edge that captures the data of a write to the same address sees the new lanes merged with the old word. Back-to-back writes to one address followed by a read return all merged lanes.
- R8: `drive_en` rises together with read data. Suppose deselect (or sleep) cycles are sampled at edges D and D+1 with no read or write between them. Then `drive_en` falls at edge D+2, and a single deselect cycle leaves it high.
- R9: A write sampled at edge E drives `drive_en` low at edge E+1, which is its data edge.
- R10: An edge with `sleep` high starts no operation, and a write sampled there changes nothing. A write whose address was sampled before sleep still takes its data. All contents are retained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep | input | 1 | High: sampled edge starts no operation |
| sel_n | input | 1 | Active-low select |
| wr_n | input | 1 | Low with select: write, high: read |
| be_n | input | WORD_W/9 | Active-low lane write enables |
| addr | input | ADDR_W | Word address |
| wdata | input | WORD_W | Late write data, one edge after its address |
| rdata | output | WORD_W | Registered read data |
| rd_valid | output | 1 | High for the cycle read data is fresh |
| drive_en | output | 1 | Output-bus drive enable |

## Verification
The assertions assume the following about the inputs:
- Control inputs are known on every edge after reset.
- `wdata` carries meaningful data only on the edge after a write.
- Sleep is a per-edge qualifier and not a level tied to an ongoing operation.

The stimulus keeps within these assumptions. It changes every input only on falling edges. It puts a deliberately different value on `wdata` whenever no write data is due. It reads only addresses that have been written first, so the bench model never has to guess the contents of unwritten memory.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
  localparam int LANE_W = 9;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } lw_op_e;
endpackage

// File: rtl/lw_sram_capture.sv
module lw_sram_capture
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic [LANES-1:0]  be_n,
  input  logic [ADDR_W-1:0] addr,
  output lw_op_e            cap_op,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [LANES-1:0]  cap_be_n
);
  wire start_any = !sleep && !sel_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_op   <= OP_IDLE;
      cap_addr <= '0;
      cap_be_n <= '1;
    end else if (start_any) begin
      cap_op   <= wr_n ? OP_READ : OP_WRITE;
      cap_addr <= addr;
      cap_be_n <= be_n;
    end else begin
      cap_op <= OP_IDLE;
    end
  end

  p_sleep_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> cap_op == OP_IDLE);
  p_sample_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !sel_n && !wr_n) |=> (cap_op == OP_WRITE && cap_addr == $past(addr)));
endmodule

// File: rtl/lw_sram_store.sv
module lw_sram_store
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  localparam int DW    = LANES * LANE_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lw_op_e            cap_op,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [LANES-1:0]  cap_be_n,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rd_word
);
  logic [DW-1:0]     mem [DEPTH];
  logic              pend_valid;
  logic [ADDR_W-1:0] pend_addr;
  logic [LANES-1:0]  pend_be_n;
  logic [DW-1:0]     pend_data;

  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] base,
                                               input logic [DW-1:0] upd,
                                               input logic [LANES-1:0] en_n);
    logic [DW-1:0] res;
    res = base;
    for (int i = 0; i < LANES; i++)
      if (!en_n[i]) res[i*LANE_W +: LANE_W] = upd[i*LANE_W +: LANE_W];
    return res;
  endfunction

  wire commit_fire = pend_valid;
  wire data_arrive = (cap_op == OP_WRITE);
  wire pend_hit    = pend_valid && (pend_addr == cap_addr);

  always_comb begin
    rd_word = mem[cap_addr];
    if (pend_hit) rd_word = lane_merge(mem[cap_addr], pend_data, pend_be_n);
  end

  always_ff @(posedge clk) begin
    if (commit_fire) mem[pend_addr] <= lane_merge(mem[pend_addr], pend_data, pend_be_n);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_addr  <= '0;
      pend_be_n  <= '1;
      pend_data  <= '0;
    end else begin
      pend_valid <= data_arrive;
      if (data_arrive) begin
        pend_addr <= cap_addr;
        pend_be_n <= cap_be_n;
        pend_data <= wdata;
      end
    end
  end

  p_pend_retire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_valid && !data_arrive) |=> !pend_valid);
  p_late_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    data_arrive |=> (pend_valid && pend_data == $past(wdata)));
endmodule

// File: rtl/lw_sram_oseq.sv
module lw_sram_oseq
  import lw_sram_pkg::*;
#(
  parameter int DW       = 36,
  parameter int DSEL_CYC = 2,
  localparam int CW      = $clog2(DSEL_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  lw_op_e        cap_op,
  input  logic [DW-1:0] rd_word,
  output logic [DW-1:0] rdata,
  output logic          rd_valid,
  output logic          drive_en
);
  logic [CW-1:0] dsel_cnt;

  wire is_read     = (cap_op == OP_READ);
  wire is_write    = (cap_op == OP_WRITE);
  wire dsel_expire = (cap_op == OP_IDLE) && (dsel_cnt == CW'(DSEL_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
      drive_en <= 1'b0;
      dsel_cnt <= '0;
    end else begin
      rd_valid <= is_read;
      if (is_read) begin
        rdata    <= rd_word;
        drive_en <= 1'b1;
        dsel_cnt <= '0;
      end else if (is_write) begin
        drive_en <= 1'b0;
        dsel_cnt <= '0;
      end else if (dsel_expire) begin
        drive_en <= 1'b0;
      end else begin
        dsel_cnt <= dsel_cnt + 1'b1;
      end
    end
  end

  p_read_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    is_read |=> (rd_valid && drive_en));
  p_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !is_read |=> $stable(rdata));
  p_write_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    is_write |=> (!drive_en && !rd_valid));
  p_drive_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_en) |-> rd_valid);
  p_dsel_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (DSEL_CYC > 1 && cap_op == OP_IDLE && drive_en && dsel_cnt == '0) |=> drive_en);
endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int WORD_W   = 36,
  parameter int ADDR_W   = 6,
  parameter int DSEL_CYC = 2,
  localparam int LANES   = WORD_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic [LANES-1:0]  be_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              rd_valid,
  output logic              drive_en
);
  generate
    if (WORD_W != 18 && WORD_W != 36) begin : g_bad_width
      $error("lw_sram: WORD_W must be 18 or 36");
    end
  endgenerate

  lw_op_e            cap_op;
  logic [ADDR_W-1:0] cap_addr;
  logic [LANES-1:0]  cap_be_n;
  logic [WORD_W-1:0] rd_word;

  lw_sram_capture #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cap (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .sel_n(sel_n), .wr_n(wr_n),
    .be_n(be_n), .addr(addr),
    .cap_op(cap_op), .cap_addr(cap_addr), .cap_be_n(cap_be_n)
  );

  lw_sram_store #(.ADDR_W(ADDR_W), .LANES(LANES)) u_store (
    .clk(clk), .rst_n(rst_n), .cap_op(cap_op), .cap_addr(cap_addr),
    .cap_be_n(cap_be_n), .wdata(wdata), .rd_word(rd_word)
  );

  lw_sram_oseq #(.DW(WORD_W), .DSEL_CYC(DSEL_CYC)) u_oseq (
    .clk(clk), .rst_n(rst_n), .cap_op(cap_op), .rd_word(rd_word),
    .rdata(rdata), .rd_valid(rd_valid), .drive_en(drive_en)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!rd_valid && !drive_en && rdata == '0));
endmodule

// File: tb/lw_sram_tb_top.sv
module lw_sram_tb_top;
  localparam int W = 36;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep = 1'b0, sel_n = 1'b1, wr_n = 1'b1;
  logic [3:0] be_n = 4'hF;
  logic [AW-1:0] addr = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic rd_valid, drive_en;

  always #10 clk = ~clk;

  lw_sram #(.WORD_W(W), .ADDR_W(AW), .DSEL_CYC(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .sel_n(sel_n), .wr_n(wr_n),
    .be_n(be_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rd_valid(rd_valid), .drive_en(drive_en)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0, mon_on = 0;
  logic [W-1:0] model [64];
  logic [W-1:0] exp_q [$];
  string        tag_q [$];
  int           drv_op = 0;           // 0 idle, 1 read, 2 write (as sampled)
  logic [W-1:0] late_data = '0;
  bit           late_due = 0;

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // lanes with enable low take the new value (R4)
  function automatic logic [W-1:0] apply_lanes(input logic [W-1:0] old, input logic [W-1:0] nw,
                                               input logic [3:0] en_n);
    logic [W-1:0] r = old;
    for (int k = 0; k < 4; k++) if (en_n[k] == 1'b0) r[9*k +: 9] = nw[9*k +: 9];
    return r;
  endfunction

  // driver: one cycle per call, inputs change on the falling edge
  task automatic issue(input int kind, input int a, input logic [3:0] ben,
                       input logic [W-1:0] d, input bit slp, input string tag);
    int eff;
    @(negedge clk);
    sel_n = (kind == 0);
    wr_n  = (kind != 2);
    addr  = AW'(a);
    be_n  = ben;
    sleep = slp;
    wdata = late_due ? late_data : ~d;  // off-cycle data differs on purpose (R3)
    eff = slp ? 0 : kind;
    late_due = 0;
    if (eff == 2) begin
      model[a] = apply_lanes(model[a], d, ben);
      late_data = d;
      late_due = 1;
    end else if (eff == 1) begin
      exp_q.push_back(model[a]);
      tag_q.push_back(tag);
    end
    drv_op = eff;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) issue(0, 0, 4'hF, '0, 0, "");
  endtask

  // monitor: outputs after edge E reflect the op sampled at edge E-1
  initial begin
    int prev = 0;
    bit m_drive = 0;
    int m_cnt = 0;
    logic [W-1:0] m_rdata = '0;
    string rtag = "R6";
    forever begin
      @(posedge clk);
      #5;
      if (mon_on) begin
        if (prev == 1) begin
          if (exp_q.size() > 0) begin
            m_rdata = exp_q.pop_front();
            rtag = tag_q.pop_front();
          end else begin
            check("R6 unexpected read", 1, 0);
          end
          m_drive = 1; m_cnt = 0;
        end else if (prev == 2) begin
          m_drive = 0; m_cnt = 0;
        end else begin
          if (m_cnt == 1) m_drive = 0; else m_cnt++;
        end
        check("R6 rd_valid", W'(rd_valid), W'(prev == 1));
        check((prev == 2) ? "R9 drive_en" : "R8 drive_en", W'(drive_en), W'(m_drive));
        check((prev == 1) ? rtag : "R6 hold", rdata, m_rdata);
        prev = drv_op;
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R6 watchdog act=%0d exp=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rd_valid", W'(rd_valid), '0);
    check("R1 drive_en", W'(drive_en), '0);
    check("R1 rdata", rdata, '0);
    rst_n = 1'b1;
    mon_on = 1;
    idle(2);

    // fill and read back (R2)
    for (int i = 0; i < 10; i++) issue(2, i, 4'h0, 36'h1_0000_0000 * i + 36'h0_1234_5678 + i, 0, "");
    for (int i = 0; i < 10; i++) issue(1, i, 4'h0, '0, 0, "R2 read back");
    idle(3);

    // forwarding from the pending write (R7)
    issue(2, 5, 4'b1110, 36'h0_0000_01AB, 0, "");
    issue(1, 5, 4'h0, '0, 0, "R7 forward");
    issue(2, 5, 4'b1011, 36'h0_0ACE_0000, 0, "");
    issue(2, 5, 4'b0111, 36'hF_0000_0000, 0, "");
    issue(1, 5, 4'h0, '0, 0, "R7 back-to-back");
    idle(1);

    // partial lanes (R4)
    issue(2, 6, 4'b0101, 36'hA_BCDE_F012, 0, "");
    idle(2);
    issue(1, 6, 4'h0, '0, 0, "R4 lanes");

    // abort (R5)
    issue(2, 7, 4'hF, 36'hF_FFFF_FFFF, 0, "");
    idle(1);
    issue(1, 7, 4'h0, '0, 0, "R5 abort");

    // late data only (R3)
    issue(2, 4, 4'h0, 36'h5_5AA5_A55A, 0, "");
    idle(1);
    issue(1, 4, 4'h0, '0, 0, "R3 late data");

    // sleep (R10)
    issue(2, 2, 4'h0, 36'hD_EADB_EEF0, 1, "");
    issue(1, 2, 4'h0, '0, 0, "R10 sleep write");
    issue(2, 3, 4'h0, 36'h3_3333_3333, 0, "");
    issue(1, 3, 4'h0, '0, 1, "");
    issue(1, 3, 4'h0, '0, 0, "R10 data during sleep");

    // deselect patterns (R8)
    issue(1, 1, 4'h0, '0, 0, "R8 read");
    idle(1);
    issue(1, 0, 4'h0, '0, 0, "R8 read");
    idle(3);
    issue(1, 8, 4'h0, '0, 0, "R8 read");
    issue(1, 9, 4'h0, '0, 0, "R8 read");
    issue(2, 9, 4'h0, 36'h0_9999_0000, 0, "");
    idle(4);

    check("R6 pending reads", W'(exp_q.size()), '0);
    mon_on = 0;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule